// File: doc/BRIEF.md
# Tagged Asynchronous Serial Receiver

This block turns a serial receive line into parallel characters. It counts a 16x oversample enable, confirms each start bit in the middle of its bit period, and takes every later bit at the centre of that bit's sixteen ticks. Each character carries two error tags, one for parity and one for framing. The character and its tags go into a two-entry buffer, and a host reads them out as one 16-bit word.

The host sets the character length, the parity mode and the number of stop bits through static configuration inputs. It turns reception on and off with one-cycle commands and removes the oldest word with a read strobe. Two sticky flags are meant to drive an interrupt line. One reports that a word was stored. The other reports that a character was lost because the buffer was full. The line input is assumed to be synchronised to `clk` already.

Top module: `uart_rx_tagged`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `valid_o`, `flag_avail_o` and `flag_ovf_o` are low, `rx_word_o` is zero and reception is disabled.
- R2: Characters are taken LSB first with `cfg_dbits_i` data bits (5 to 9). The word places them right-aligned in bits 8:0, with unused data bits at 0. Bits 13:9 always read 0.
- R3: A low level on the idle line is confirmed on the 8th oversample tick after it is seen. If the line is high again at that point, the receiver returns to idle and stores nothing.
- R4: `cfg_par_i` selects the parity mode: 2'b0x means no parity bit, 2'b10 means even and 2'b11 means odd. A parity bit that does not match the received data sets bit 14 of the stored word.
- R5: A first stop bit sampled low sets bit 15 of the stored word. When `cfg_two_stop_i` is 1, the second stop bit is waited out but never checked, and it produces no extra word.
- R6: A line held low through a whole frame is stored as a word with bit 15 set and bits 8:0 all zero.
- R7: The buffer holds two words. `valid_o` is high while at least one word is waiting. `rd_i` removes the oldest word, and `rd_i` on an empty buffer has no effect.
- R8: A character that completes while both entries are full is dropped. The stored words stay unchanged and the sticky overflow flag `flag_ovf_o` is set.
- R9: `flag_avail_o` is set whenever a word is stored. Each flag stays set until its clear bit is pulsed (`flag_clr_i[0]` for the stored-word flag, `flag_clr_i[1]` for the overflow flag). A set in the same cycle as a clear wins.
- R10: Reception runs only after an `en_cmd_i` pulse. A `dis_cmd_i` pulse stops it, wins over a simultaneous enable, abandons any frame in progress and keeps the words already buffered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Oversample enable, 16 per bit period |
| rx_i | input | 1 | Serial line, idle high, already synchronised |
| cfg_dbits_i | input | 4 | Data bits per character, 5 to 9 |
| cfg_par_i | input | 2 | Parity mode: 0x none, 10 even, 11 odd |
| cfg_two_stop_i | input | 1 | 1 selects two stop bits |
| en_cmd_i | input | 1 | One-cycle command that enables reception |
| dis_cmd_i | input | 1 | One-cycle command that disables reception |
| rd_i | input | 1 | Removes the oldest buffered word |
| flag_clr_i | input | 2 | Clear pulses: bit 0 stored-word flag, bit 1 overflow flag |
| rx_word_o | output | 16 | Oldest word: data 8:0, parity error 14, framing error 15; zero when empty |
| valid_o | output | 1 | At least one word buffered |
| flag_avail_o | output | 1 | Sticky: a word was stored |
| flag_ovf_o | output | 1 | Sticky: a character was dropped |

## Verification
The bench sends clean frames at three character lengths, with and without parity, and checks that bit ordering and right alignment hold at every length. It then sends frames that each differ from a clean one in a single field: a flipped parity bit, a low first stop bit, a low second stop bit, and a line held low for a whole frame. This shows that each tag answers to its own field only, and that a break is told apart from a plain framing error by its zero data. A short low pulse separates start validation from start detection. Three frames sent back to back without reads, and frames sent while disabled or after a combined enable-and-disable, separate dropping from storing and gating from buffering.

// File: rtl/rxt_pkg.sv
// Shared constants and types for the tagged receiver.
// Assumes a fixed 16-bit read-out word whose tag positions are behaviour.
package rxt_pkg;
    localparam int DATA_W   = 9;
    localparam int MIN_BITS = 5;
    localparam int WORD_W   = 16;
    localparam int PERR_POS = 14;
    localparam int FERR_POS = 15;
    localparam int PAD_W    = WORD_W - 2 - DATA_W;
    localparam int DB_W     = $clog2(DATA_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_char_t;

    localparam int CHAR_W = $bits(rx_char_t);
endpackage

// File: rtl/rxt_framer.sv
// Frame assembler: finds the start bit, samples each bit at its centre and
// emits one tagged character per frame as a one-cycle push.
// Assumes rx_i is synchronous and tick_i comes OSR times per bit period.
module rxt_framer
    import rxt_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active_i,
    input  logic            tick_i,
    input  logic            rx_i,
    input  logic [DB_W-1:0] cfg_dbits_i,
    input  logic [1:0]      cfg_par_i,
    input  logic            cfg_two_stop_i,
    output logic            push_o,
    output rx_char_t        char_o
);
    localparam int TC_W = $clog2(OSR);
    localparam logic [TC_W-1:0] MID  = TC_W'(OSR / 2 - 1);
    localparam logic [TC_W-1:0] LAST = TC_W'(OSR - 1);

    rx_state_e         st;
    logic [TC_W-1:0]   tcnt;
    logic [DB_W-1:0]   bcnt;
    logic [DB_W-1:0]   nbits;
    logic [DATA_W-1:0] shreg;
    logic              pbit_q;

    // Clamp the configured length into the supported range.
    always_comb begin
        if (cfg_dbits_i < DB_W'(MIN_BITS))
            nbits = DB_W'(MIN_BITS);
        else if (cfg_dbits_i > DB_W'(DATA_W))
            nbits = DB_W'(DATA_W);
        else
            nbits = cfg_dbits_i;
    end

    // Bit-level state machine, advanced only on oversample ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            tcnt   <= '0;
            bcnt   <= '0;
            shreg  <= '0;
            pbit_q <= 1'b0;
            push_o <= 1'b0;
            char_o <= '0;
        end else begin
            push_o <= 1'b0;
            if (!active_i) begin
                st   <= ST_IDLE;
                tcnt <= '0;
            end else if (tick_i) begin
                case (st)
                    ST_IDLE: begin
                        if (!rx_i) begin
                            st   <= ST_START;
                            tcnt <= '0;
                        end
                    end
                    ST_START: begin
                        if (tcnt == MID) begin
                            tcnt  <= '0;
                            bcnt  <= '0;
                            shreg <= '0;
                            st    <= rx_i ? ST_IDLE : ST_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (tcnt == LAST) begin
                            tcnt        <= '0;
                            shreg[bcnt] <= rx_i;
                            if (bcnt == nbits - 1'b1)
                                st <= cfg_par_i[1] ? ST_PAR : ST_STOP;
                            else
                                bcnt <= bcnt + 1'b1;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (tcnt == LAST) begin
                            tcnt   <= '0;
                            pbit_q <= rx_i;
                            st     <= ST_STOP;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (tcnt == LAST) begin
                            tcnt        <= '0;
                            push_o      <= 1'b1;
                            char_o.data <= shreg;
                            char_o.perr <= cfg_par_i[1] & (^shreg ^ pbit_q ^ cfg_par_i[0]);
                            char_o.ferr <= ~rx_i;
                            st          <= cfg_two_stop_i ? ST_STOP2 : ST_IDLE;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_STOP2: begin
                        if (tcnt == LAST) begin
                            tcnt <= '0;
                            st   <= ST_IDLE;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rxt_fifo.sv
// Small receive buffer: stores on push unless full, drops otherwise.
// Assumes pop is ignored when empty; head data is meaningful only when valid.
module rxt_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         valid_o,
    output logic         full_o,
    output logic         stored_o,
    output logic         dropped_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_pop;

    assign valid_o   = (count != '0);
    assign full_o    = (count == CNT_W'(DEPTH));
    assign stored_o  = push_i & ~full_o;
    assign dropped_o = push_i & full_o;
    assign do_pop    = pop_i & valid_o;
    assign dout_o    = mem[rd_ptr];

    // Entry storage; written only when a push is accepted.
    always_ff @(posedge clk) begin
        if (stored_o)
            mem[wr_ptr] <= din_i;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (stored_o)
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            if (stored_o && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !stored_o)
                count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/rxt_flags.sv
// Receiver enable state and the two sticky event flags.
// Assumes the commands and clears are single-cycle pulses.
module rxt_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_cmd_i,
    input  logic       dis_cmd_i,
    input  logic       stored_i,
    input  logic       dropped_i,
    input  logic [1:0] clr_i,
    output logic       active_o,
    output logic       avail_o,
    output logic       ovf_o
);
    // Enable state: a disable beats a simultaneous enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_o <= 1'b0;
        else if (dis_cmd_i)
            active_o <= 1'b0;
        else if (en_cmd_i)
            active_o <= 1'b1;
    end

    // Sticky flags: a new event beats a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avail_o <= 1'b0;
            ovf_o   <= 1'b0;
        end else begin
            avail_o <= stored_i  | (avail_o & ~clr_i[0]);
            ovf_o   <= dropped_i | (ovf_o   & ~clr_i[1]);
        end
    end
endmodule

// File: rtl/uart_rx_tagged.sv
// Top of the tagged receiver: framer, two-entry buffer and flag logic.
// Assumes a synchronised line input and a 16x oversample enable.
module uart_rx_tagged
    import rxt_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rx_i,
    input  logic [DB_W-1:0]   cfg_dbits_i,
    input  logic [1:0]        cfg_par_i,
    input  logic              cfg_two_stop_i,
    input  logic              en_cmd_i,
    input  logic              dis_cmd_i,
    input  logic              rd_i,
    input  logic [1:0]        flag_clr_i,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              valid_o,
    output logic              flag_avail_o,
    output logic              flag_ovf_o
);
    logic              rx_active;
    logic              frm_push;
    rx_char_t          frm_char;
    logic [CHAR_W-1:0] buf_dout;
    rx_char_t          head;
    logic              buf_full;
    logic              buf_stored;
    logic              buf_dropped;

    rxt_framer #(.OSR(OSR)) u_framer (
        .clk            (clk),
        .rst_n          (rst_n),
        .active_i       (rx_active),
        .tick_i         (tick_i),
        .rx_i           (rx_i),
        .cfg_dbits_i    (cfg_dbits_i),
        .cfg_par_i      (cfg_par_i),
        .cfg_two_stop_i (cfg_two_stop_i),
        .push_o         (frm_push),
        .char_o         (frm_char)
    );

    rxt_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (frm_push),
        .din_i     (frm_char),
        .pop_i     (rd_i),
        .dout_o    (buf_dout),
        .valid_o   (valid_o),
        .full_o    (buf_full),
        .stored_o  (buf_stored),
        .dropped_o (buf_dropped)
    );

    rxt_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_cmd_i  (en_cmd_i),
        .dis_cmd_i (dis_cmd_i),
        .stored_i  (buf_stored),
        .dropped_i (buf_dropped),
        .clr_i     (flag_clr_i),
        .active_o  (rx_active),
        .avail_o   (flag_avail_o),
        .ovf_o     (flag_ovf_o)
    );

    // Format the head entry into the read-out word; zero while empty.
    always_comb begin
        head      = rx_char_t'(buf_dout);
        rx_word_o = '0;
        if (valid_o)
            rx_word_o = {head.ferr, head.perr, {PAD_W{1'b0}}, head.data};
    end
endmodule

// File: rtl/rxt_checker.sv
// Temporal properties of the tagged receiver, bound into the top module.
// Assumes it observes the top's internal push, full and enable signals.
module rxt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        push_w,
    input logic        full_w,
    input logic        active_w,
    input logic        rd_i,
    input logic [1:0]  flag_clr_i,
    input logic [15:0] rx_word_o,
    input logic        valid_o,
    input logic        flag_avail_o,
    input logic        flag_ovf_o
);
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !active_w |=> !push_w); // R10
    AST_STORE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n) push_w && !full_w |=> valid_o && flag_avail_o); // R7
    AST_OVF_RAISED: assert property (@(posedge clk) disable iff (!rst_n) push_w && full_w |=> flag_ovf_o); // R8
    AST_DROP_KEEPS_HEAD: assert property (@(posedge clk) disable iff (!rst_n) push_w && full_w && !rd_i |=> $stable(rx_word_o)); // R8
    AST_OVF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) flag_ovf_o && !flag_clr_i[1] |=> flag_ovf_o); // R9
    AST_AVAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) flag_avail_o && !flag_clr_i[0] |=> flag_avail_o); // R9
    AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n) !valid_o && !push_w |=> !valid_o); // R7
endmodule

bind uart_rx_tagged rxt_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_w       (frm_push),
    .full_w       (buf_full),
    .active_w     (rx_active),
    .rd_i         (rd_i),
    .flag_clr_i   (flag_clr_i),
    .rx_word_o    (rx_word_o),
    .valid_o      (valid_o),
    .flag_avail_o (flag_avail_o),
    .flag_ovf_o   (flag_ovf_o)
);

// File: tb/uart_rx_tagged_bench.sv
module uart_rx_tagged_bench;
    localparam int CLK_P  = 10;
    localparam int BIT_CY = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        rx_i = 1'b1;
    logic [3:0]  cfg_dbits_i = 4'd8;
    logic [1:0]  cfg_par_i = 2'b00;
    logic        cfg_two_stop_i = 1'b0;
    logic        en_cmd_i = 1'b0;
    logic        dis_cmd_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [1:0]  flag_clr_i = 2'b00;
    logic [15:0] rx_word_o;
    logic        valid_o;
    logic        flag_avail_o;
    logic        flag_ovf_o;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    uart_rx_tagged u_uart_rx_tagged (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_i         (tick_i),
        .rx_i           (rx_i),
        .cfg_dbits_i    (cfg_dbits_i),
        .cfg_par_i      (cfg_par_i),
        .cfg_two_stop_i (cfg_two_stop_i),
        .en_cmd_i       (en_cmd_i),
        .dis_cmd_i      (dis_cmd_i),
        .rd_i           (rd_i),
        .flag_clr_i     (flag_clr_i),
        .rx_word_o      (rx_word_o),
        .valid_o        (valid_o),
        .flag_avail_o   (flag_avail_o),
        .flag_ovf_o     (flag_ovf_o)
    );

    always #(CLK_P / 2) clk = ~clk;

    // Oversample enable on every second cycle: 32 cycles per bit.
    always @(posedge clk) tick_i <= ~tick_i;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold_bits(input logic lvl, input int nbit);
        rx_i = lvl;
        repeat (nbit * BIT_CY) @(negedge clk);
    endtask

    // Sends one frame; the flags corrupt single fields.
    task automatic send_frame(input logic [8:0] data, input logic flip_par,
                              input logic stop1, input logic stop2);
        logic p;
        int   nb;
        nb = int'(cfg_dbits_i);
        p = 1'b0;
        for (int i = 0; i < nb; i++) p ^= data[i];
        p = p ^ cfg_par_i[0] ^ flip_par;
        hold_bits(1'b0, 1);
        for (int i = 0; i < nb; i++) hold_bits(data[i], 1);
        if (cfg_par_i[1]) hold_bits(p, 1);
        hold_bits(stop1, 1);
        if (cfg_two_stop_i) hold_bits(stop2, 1);
        hold_bits(1'b1, 2);
    endtask

    task automatic pulse_rd();
        rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clr(input logic [1:0] c);
        flag_clr_i = c;
        @(negedge clk);
        flag_clr_i = 2'b00;
        @(negedge clk);
    endtask

    task automatic expect_one(input string req, input logic [15:0] exp);
        chk({req, " valid"}, 32'(valid_o), 32'd1);
        chk({req, " word"}, 32'(rx_word_o), 32'(exp));
        pulse_rd();
        chk({req, " single word"}, 32'(valid_o), 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 valid", 32'(valid_o), 32'd0);
        chk("R1 word", 32'(rx_word_o), 32'd0);
        chk("R1 avail", 32'(flag_avail_o), 32'd0);
        chk("R1 ovf", 32'(flag_ovf_o), 32'd0);
        send_frame(9'h5A, 1'b0, 1'b1, 1'b1);
        chk("R1 disabled after reset", 32'(valid_o), 32'd0);
    endtask

    task automatic t_basic();
        en_cmd_i = 1'b1;
        @(negedge clk);
        en_cmd_i = 1'b0;
        cfg_dbits_i = 4'd8; cfg_par_i = 2'b00;
        send_frame(9'h0A5, 1'b0, 1'b1, 1'b1);
        chk("R9 avail set", 32'(flag_avail_o), 32'd1);
        expect_one("R2 8N1", 16'h00A5);
        pulse_rd();
        chk("R7 pop when empty", 32'(valid_o), 32'd0);
        chk("R9 avail sticky", 32'(flag_avail_o), 32'd1);
        pulse_clr(2'b01);
        chk("R9 avail cleared", 32'(flag_avail_o), 32'd0);
    endtask

    task automatic t_widths();
        cfg_dbits_i = 4'd5; cfg_par_i = 2'b00;
        send_frame(9'h015, 1'b0, 1'b1, 1'b1);
        expect_one("R2 5 bits", 16'h0015);
        cfg_dbits_i = 4'd9; cfg_par_i = 2'b10;
        send_frame(9'h1A3, 1'b0, 1'b1, 1'b1);
        expect_one("R2 9 bits even", 16'h01A3);
    endtask

    task automatic t_parity();
        cfg_dbits_i = 4'd7; cfg_par_i = 2'b11;
        send_frame(9'h035, 1'b0, 1'b1, 1'b1);
        expect_one("R4 odd ok", 16'h0035);
        send_frame(9'h035, 1'b1, 1'b1, 1'b1);
        expect_one("R4 odd bad", 16'h4035);
        cfg_dbits_i = 4'd8; cfg_par_i = 2'b10;
        send_frame(9'h0C3, 1'b1, 1'b1, 1'b1);
        expect_one("R4 even bad", 16'h40C3);
    endtask

    task automatic t_framing();
        cfg_dbits_i = 4'd8; cfg_par_i = 2'b00; cfg_two_stop_i = 1'b0;
        send_frame(9'h03C, 1'b0, 1'b0, 1'b1);
        expect_one("R5 low stop", 16'h803C);
        cfg_two_stop_i = 1'b1;
        send_frame(9'h081, 1'b0, 1'b1, 1'b0);
        expect_one("R5 second stop unchecked", 16'h0081);
        cfg_two_stop_i = 1'b0;
    endtask

    task automatic t_glitch();
        rx_i = 1'b0;
        repeat (6) @(negedge clk);
        hold_bits(1'b1, 4);
        chk("R3 short low ignored", 32'(valid_o), 32'd0);
        send_frame(9'h066, 1'b0, 1'b1, 1'b1);
        expect_one("R3 next frame ok", 16'h0066);
    endtask

    task automatic t_break();
        cfg_dbits_i = 4'd8; cfg_par_i = 2'b00;
        hold_bits(1'b0, 10);
        hold_bits(1'b1, 3);
        expect_one("R6 break", 16'h8000);
    endtask

    task automatic t_overflow();
        pulse_clr(2'b11);
        send_frame(9'h011, 1'b0, 1'b1, 1'b1);
        send_frame(9'h022, 1'b0, 1'b1, 1'b1);
        chk("R8 no ovf at two", 32'(flag_ovf_o), 32'd0);
        send_frame(9'h033, 1'b0, 1'b1, 1'b1);
        chk("R8 ovf set", 32'(flag_ovf_o), 32'd1);
        chk("R8 oldest kept", 32'(rx_word_o), 32'h0011);
        pulse_rd();
        chk("R8 second kept", 32'(rx_word_o), 32'h0022);
        pulse_rd();
        chk("R8 third dropped", 32'(valid_o), 32'd0);
        chk("R9 ovf sticky", 32'(flag_ovf_o), 32'd1);
        pulse_clr(2'b10);
        chk("R9 ovf cleared", 32'(flag_ovf_o), 32'd0);
    endtask

    task automatic t_disable();
        send_frame(9'h04D, 1'b0, 1'b1, 1'b1);
        dis_cmd_i = 1'b1;
        @(negedge clk);
        dis_cmd_i = 1'b0;
        send_frame(9'h0E7, 1'b0, 1'b1, 1'b1);
        chk("R10 disabled keeps word", 32'(rx_word_o), 32'h004D);
        pulse_rd();
        chk("R10 disabled stores nothing", 32'(valid_o), 32'd0);
        en_cmd_i = 1'b1; dis_cmd_i = 1'b1;
        @(negedge clk);
        en_cmd_i = 1'b0; dis_cmd_i = 1'b0;
        send_frame(9'h0E7, 1'b0, 1'b1, 1'b1);
        chk("R10 disable wins", 32'(valid_o), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_widths();
        t_parity();
        t_framing();
        t_glitch();
        t_break();
        t_overflow();
        t_disable();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule